// File: doc/BRIEF.md
# Lockstep Multi-Lane Request Queue

This block buffers requests arriving on several parallel lanes. The lanes move together, one row at a time. On a cycle when the queue can accept and at least one lane presents a request, every lane's input is written into one new row. A lane that was not presenting leaves an empty slot in that row. The rows form a shift queue, and only the oldest row, the head, is visible at the outputs.

Each lane has a hold input. While a lane's hold is high, its head entry is kept back for a later merging stage and is not offered downstream. Entries taken from the head are cleared one lane at a time. The head row retires only when none of its valid entries remain. At that point the next row moves up. When every row is occupied, the queue can still accept a new row in the same cycle that the head row retires, so a full queue keeps streaming without a gap.

Top module: `lockstep_req_queue`

## Requirements
- R1: Reset clears every slot. During reset and on the first cycle after it, all dequeue valids are low and the shared enqueue ready is high.
- R2: A cycle with `enq_ready` high and any `enq_valid` bit set writes exactly one row. Lane l of that row holds `enq_data[l*W +: W]` and is valid only if `enq_valid[l]` was set. Rows leave the queue in the order they were written. A cycle with all `enq_valid` bits low writes no row.
- R3: `deq_valid[l]` is high exactly when the head row exists, its lane l slot is valid, and `hold[l]` is low. `deq_data[l*W +: W]` then carries that slot's payload.
- R4: While every lane's hold is high, no lane dequeues, whatever `deq_ready` shows.
- R5: A head entry with `deq_valid` and `deq_ready` both high is removed at the clock edge. Entries of the head row that were not taken stay in place. The head does not shift while any of its valid entries remain.
- R6: Slots that were empty when their row was written never hold back that row's retirement. The next row becomes the head on the cycle after the last valid head entry is taken.
- R7: `enq_ready` is one signal for all lanes. It is high unless all DEPTH rows are occupied. When they are, it is high only if the head row's last valid entries are being taken in that same cycle.
- R8: If the queue is full and, every cycle, a new row is presented while the whole head row is taken, the queue accepts and delivers one row per cycle with no idle cycle.
- R9: When no row is held, all dequeue valids are low and nothing shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | LANES | Per-lane request present |
| enq_data | input | LANES*W | Per-lane request payloads, lane l at bits l*W +: W |
| enq_ready | output | 1 | Shared acceptance of a new row |
| hold | input | LANES | Per-lane hold of the head entry for merging |
| deq_valid | output | LANES | Per-lane head entry offered |
| deq_data | output | LANES*W | Per-lane head payloads |
| deq_ready | input | LANES | Per-lane downstream acceptance |

## Verification
The case most likely to go wrong is a full queue in which the head row retires and a new row is written in the same cycle. The write slot then sits one row lower than it would without the shift, and the ready signal depends on the dequeue taking place in that cycle. The bench fills the queue while every hold is set, then releases all holds with all readies high and presents a new row every cycle. Each cycle it compares ready, valids and payloads with a row-queue model, and it separately runs a long stretch of random hold, ready and valid patterns that reach this overlap from partly drained heads as well.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int unsigned LSQ_LANES_DEF = 4;
  localparam int unsigned LSQ_DEPTH_DEF = 4;
  localparam int unsigned LSQ_WIDTH_DEF = 8;
endpackage

// File: rtl/lsq_lane.sv
module lsq_lane #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             take,
  output logic             head_vld,
  output logic [WIDTH-1:0] head_data
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [WIDTH-1:0] dat_q [DEPTH];
  logic [WIDTH-1:0] dat_d [DEPTH];

  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < DEPTH; i++) dat_d[i] = dat_q[i];
    if (shift) begin
      vld_d = {1'b0, vld_q[DEPTH-1:1]};
      for (int i = 0; i < DEPTH - 1; i++) dat_d[i] = dat_q[i+1];
    end else if (take) begin
      vld_d[0] = 1'b0;
    end
    if (wr_en) begin
      vld_d[wr_idx] = wr_vld;
      dat_d[wr_idx] = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) dat_q[i] <= dat_d[i];
  end

  assign head_vld  = vld_q[0];
  assign head_data = dat_q[0];
endmodule

// File: rtl/lsq_ctrl.sv
module lsq_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_any,
  input  logic             head_left,
  output logic             enq_ready,
  output logic             shift,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [CNT_W-1:0] row_cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] slot;
  logic occupied, full;

  assign occupied  = (cnt_q != '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign shift     = occupied & ~head_left;
  assign enq_ready = ~full | shift;
  assign wr_en     = enq_ready & enq_any;
  assign slot      = cnt_q - CNT_W'(shift);
  assign wr_idx    = slot[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + CNT_W'(wr_en) - CNT_W'(shift);
  end

  assign row_cnt = cnt_q;
endmodule

// File: rtl/lockstep_req_queue.sv
module lockstep_req_queue #(
  parameter int unsigned LANES = lsq_pkg::LSQ_LANES_DEF,
  parameter int unsigned DEPTH = lsq_pkg::LSQ_DEPTH_DEF,
  parameter int unsigned W     = lsq_pkg::LSQ_WIDTH_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES-1:0]   enq_valid,
  input  logic [LANES*W-1:0] enq_data,
  output logic               enq_ready,
  input  logic [LANES-1:0]   hold,
  output logic [LANES-1:0]   deq_valid,
  output logic [LANES*W-1:0] deq_data,
  input  logic [LANES-1:0]   deq_ready
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [LANES-1:0] head_vld;
  logic [LANES-1:0] take;
  logic             head_left;
  logic             shift, wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [CNT_W-1:0] row_cnt;

  assign deq_valid = head_vld & ~hold;
  assign take      = deq_valid & deq_ready;
  assign head_left = |(head_vld & ~take);

  lsq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .enq_any(|enq_valid), .head_left(head_left),
    .enq_ready(enq_ready), .shift(shift), .wr_en(wr_en), .wr_idx(wr_idx),
    .row_cnt(row_cnt)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lsq_lane #(.DEPTH(DEPTH), .WIDTH(W)) u_lane (
      .clk(clk), .rst(rst), .shift(shift), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_vld(enq_valid[l]), .wr_data(enq_data[l*W +: W]), .take(take[l]),
      .head_vld(head_vld[l]), .head_data(deq_data[l*W +: W])
    );
  end
endmodule

// File: rtl/lsq_chk.sv
module lsq_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic [LANES-1:0]   enq_valid,
  input logic               enq_ready,
  input logic [LANES-1:0]   hold,
  input logic [LANES-1:0]   deq_valid,
  input logic [LANES*W-1:0] deq_data,
  input logic [LANES-1:0]   deq_ready,
  input logic [CNT_W-1:0]   row_cnt
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (deq_valid == '0 && enq_ready));
  // R3
  hold_gate_chk: assert property (@(posedge clk) disable iff (rst) (deq_valid & hold) == '0);
  // R9
  empty_quiet_chk: assert property (@(posedge clk) disable iff (rst) (row_cnt == '0) |-> (deq_valid == '0));
  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (row_cnt == CNT_W'(DEPTH) && (deq_valid & deq_ready) == '0) |-> !enq_ready);
  // R2
  row_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (enq_ready && (|enq_valid) && (deq_valid & deq_ready) == '0) |=> (row_cnt == $past(row_cnt) + 1'b1));
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) row_cnt <= CNT_W'(DEPTH));
  for (genvar l = 0; l < LANES; l++) begin : g_stab
    // R5
    head_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (deq_valid[l] && !deq_ready[l]) |=> $stable(deq_data[l*W +: W]));
  end
endmodule

bind lockstep_req_queue lsq_chk #(.LANES(LANES), .DEPTH(DEPTH), .W(W)) u_chk (
  .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_ready(enq_ready), .hold(hold),
  .deq_valid(deq_valid), .deq_data(deq_data), .deq_ready(deq_ready), .row_cnt(row_cnt)
);

// File: tb/sim_lockstep_req_queue.sv
module sim_lockstep_req_queue;
  localparam int LANES = 4;
  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int TCK   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES-1:0]    enq_valid = '0;
  logic [LANES*DW-1:0] enq_data = '0;
  logic                enq_ready;
  logic [LANES-1:0]    hold = '0;
  logic [LANES-1:0]    deq_valid;
  logic [LANES*DW-1:0] deq_data;
  logic [LANES-1:0]    deq_ready = '0;

  always #(TCK/2) clk = ~clk;

  lockstep_req_queue #(.LANES(LANES), .DEPTH(DEPTH), .W(DW)) u0 (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_data(enq_data), .enq_ready(enq_ready),
    .hold(hold), .deq_valid(deq_valid), .deq_data(deq_data), .deq_ready(deq_ready)
  );

  typedef struct {
    logic [LANES-1:0]    v;
    logic [LANES*DW-1:0] d;
  } row_t;
  row_t mq[$];

  int checks = 0;
  int errors = 0;
  int seq = 1;
  logic [LANES-1:0] e_fire;
  logic e_drain, e_acc;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [LANES-1:0] ev, input logic [LANES-1:0] hd, input logic [LANES-1:0] dr);
    enq_valid = ev;
    hold = hd;
    deq_ready = dr;
    for (int l = 0; l < LANES; l++) enq_data[l*DW +: DW] = DW'(seq * 7 + l * 3);
    seq++;
  endtask

  task automatic compare();
    logic [LANES-1:0] edv, rem;
    logic erdy;
    edv = '0;
    rem = '0;
    if (mq.size() > 0) edv = mq[0].v & ~hold;
    e_fire = edv & deq_ready;
    if (mq.size() > 0) rem = mq[0].v & ~e_fire;
    e_drain = (mq.size() > 0) && (rem == '0);
    erdy = (mq.size() < DEPTH) || e_drain;
    e_acc = erdy && (|enq_valid);
    chk(deq_valid === edv, "R3 deq_valid", 64'(deq_valid), 64'(edv));
    chk(enq_ready === erdy, "R7 enq_ready", 64'(enq_ready), 64'(erdy));
    for (int l = 0; l < LANES; l++)
      if (edv[l])
        chk(deq_data[l*DW +: DW] === mq[0].d[l*DW +: DW], "R2 deq_data",
            64'(deq_data[l*DW +: DW]), 64'(mq[0].d[l*DW +: DW]));
  endtask

  task automatic update();
    row_t r;
    if (mq.size() > 0) begin
      if (e_drain) void'(mq.pop_front());
      else mq[0].v = mq[0].v & ~e_fire;
    end
    if (e_acc) begin
      r.v = enq_valid;
      r.d = enq_data;
      mq.push_back(r);
    end
  endtask

  task automatic tick();
    #1;
    compare();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  initial begin
    #(TCK * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(deq_valid == '0 && enq_ready, "R1 in reset", {deq_valid, enq_ready}, 64'h1);
    rst = 1'b0;
    #1;
    chk(deq_valid == '0 && enq_ready, "R1 after reset", {deq_valid, enq_ready}, 64'h1);
    @(negedge clk);

    // R4: rows written while all lanes held
    drive(4'hF, 4'hF, 4'hF); tick();
    drive(4'b0001, 4'hF, 4'hF); tick();
    drive(4'hF, 4'hF, 4'hF); tick();
    drive(4'h0, 4'hF, 4'hF); #1;
    chk(deq_valid == '0, "R4 all held", 64'(deq_valid), 64'h0);
    tick();

    // R5: partial take keeps the head row
    drive(4'h0, 4'h0, 4'b0001); #1;
    chk(deq_valid == 4'hF, "R3 head offered", 64'(deq_valid), 64'hF);
    tick();
    drive(4'h0, 4'h0, 4'h0); #1;
    chk(deq_valid == 4'b1110, "R5 taken lane cleared", 64'(deq_valid), 64'hE);
    tick();
    drive(4'h0, 4'h0, 4'b1110); tick();
    // R6: row with lane 0 only
    drive(4'h0, 4'h0, 4'h0); #1;
    chk(deq_valid == 4'b0001, "R6 sparse row at head", 64'(deq_valid), 64'h1);
    tick();
    drive(4'h0, 4'h0, 4'b0001); tick();
    drive(4'h0, 4'h0, 4'h0); #1;
    chk(deq_valid == 4'hF, "R6 sparse row retired", 64'(deq_valid), 64'hF);
    tick();

    // R7: fill to full, then drain-and-write
    drive(4'hF, 4'hF, 4'hF); tick();
    drive(4'hF, 4'hF, 4'hF); tick();
    drive(4'hF, 4'hF, 4'hF); tick();
    drive(4'hF, 4'hF, 4'hF); #1;
    chk(enq_ready == 1'b0, "R7 full blocks", 64'(enq_ready), 64'h0);
    tick();
    drive(4'hF, 4'b0100, 4'hF); #1;
    chk(enq_ready == 1'b0, "R7 partial drain blocks", 64'(enq_ready), 64'h0);
    tick();
    drive(4'hF, 4'h0, 4'hF); #1;
    chk(enq_ready == 1'b1, "R7 full drain admits", 64'(enq_ready), 64'h1);
    tick();

    // R8: streaming at full occupancy
    for (int k = 0; k < 8; k++) begin
      drive(4'hF, 4'h0, 4'hF); #1;
      chk(deq_valid == 4'hF && enq_ready, "R8 stream", {deq_valid, enq_ready}, 64'h1F);
      tick();
    end

    // R9: drain to empty
    for (int k = 0; k < 6; k++) begin
      drive(4'h0, 4'h0, 4'hF); tick();
    end
    drive(4'h0, 4'h0, 4'hF); #1;
    chk(deq_valid == '0, "R9 empty quiet", 64'(deq_valid), 64'h0);
    tick();

    // R2: idle enqueue cycles occupy no row
    drive(4'h0, 4'h0, 4'h0); tick();
    drive(4'b0010, 4'h0, 4'h0); tick();
    drive(4'h0, 4'h0, 4'h0); #1;
    chk(deq_valid == 4'b0010, "R2 single row at head", 64'(deq_valid), 64'h2);
    tick();

    // random mix of all functions
    for (int k = 0; k < 2000; k++) begin
      logic [LANES-1:0] hd;
      hd = LANES'($urandom) & LANES'($urandom);
      drive(LANES'($urandom), hd, LANES'($urandom));
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule